// File: doc/BRIEF.md
# DMA Global Register Block

This block is the shared register front end of a 32-channel DMA controller. It sits on a simple memory-mapped register bus. Each access is decoded either into one channel's 32-byte register window, which is passed on to that channel, or into a small set of controller-wide registers that the block holds itself.

The controller-wide registers are a control word, a per-channel interrupt-pending vector, a per-channel descriptor doorbell, a per-channel programmable mask, and two pairs of pending/mask storage words. Channel data movers report completion, halt and address-error events. These events set the channel's pending bit and two sticky controller-wide error flags. One interrupt line summarises the pending vector. Software raises doorbells with write-one-to-set writes, and each channel drops its own doorbell when it accepts the descriptor fetch.

Top module: `dma_glb_regs`

## Requirements
- R1: A word-aligned access with address bit 12 clear and address bits [11:5] below 32 targets channel n = addr[9:5]. For a write, bit n of `ch_wr_o` pulses in that cycle, `ch_word_o` = addr[4:2] and `ch_wdata_o` = `wdata_i`. For a read, bit n of `ch_rd_o` pulses and `rdata_o` returns `ch_rdata_i[n]` in the same cycle.
- R2: The control word at 0x1000 stores the global enable in bit 0 and a performance-mode bit in bit 31, both read/write. Bits other than 0, 2, 3 and 31 read as 0.
- R3: A halt event on any channel sets the halt flag (control bit 3). An address-error event on any channel sets the address-error flag (control bit 2). Each flag is set on the clock edge that captures the event and stays set. A control write with 0 in a flag's bit clears that flag, and a 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R4: A completion, halt or address-error event on channel n sets bit n of the pending vector at 0x1004 on the capturing edge. A write to 0x1004 clears every bit written as 0 and keeps every bit written as 1. An event in the same cycle wins over the clear.
- R5: Writing 0x100C sets each doorbell whose data bit is 1 and leaves the others unchanged. The doorbell vector reads back at both 0x1008 and 0x100C and drives `db_o`. Writes to 0x1008 are ignored.
- R6: A pulse on `fetch_ack_i[n]` clears doorbell n on the next edge. Until then the doorbell stays set. If a set and an acknowledge for the same channel fall in the same cycle, the doorbell ends set.
- R7: The programmable mask at 0x101C is a 32-bit read/write register that drives `prog_mask_o`.
- R8: The words at 0x1020, 0x1024, 0x1028 and 0x102C are independent 32-bit read/write storage registers.
- R9: `irq_o` is high exactly when the global enable is 1 and at least one pending bit is set.
- R10: Reads of unmapped offsets return 0, and writes to them change no register and pulse no channel strobe. Unmapped offsets are 0x0400-0x0FFF, the unlisted words in 0x1000-0x103F, 0x1040 and above, and any address with addr[1:0] not zero.
- R11: After reset every register, flag and doorbell is 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 13 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle |
| ch_wr_o | output | 32 | One-hot channel write strobe |
| ch_rd_o | output | 32 | One-hot channel read strobe |
| ch_word_o | output | 3 | Word index inside channel window |
| ch_wdata_o | output | 32 | Write data passed to channel |
| ch_rdata_i | input | 32x32 | Per-channel read data |
| done_i | input | 32 | Per-channel completion event |
| halt_i | input | 32 | Per-channel halt event |
| aerr_i | input | 32 | Per-channel address-error event |
| fetch_ack_i | input | 32 | Per-channel descriptor fetch accepted |
| db_o | output | 32 | Doorbell state |
| prog_mask_o | output | 32 | Programmable mask |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and the channel strobes are combinational, so the bench checks them 1 ns after driving the access, inside the same cycle. Writes, events and acknowledges are captured on the next rising edge. Their results are therefore read back in a later cycle, after the stimulus has been driven at a falling edge and removed at the following one. `irq_o` and `db_o` follow register state with no extra stage, and they are sampled together with the next readback. The same-cycle collision cases (event against clearing write, set against acknowledge) drive both stimuli at one falling edge so that they share the capturing edge.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  localparam int WIN_LSB   = 5;   // 32-byte channel windows
  localparam int CTRL_EN   = 0;
  localparam int CTRL_AERR = 2;
  localparam int CTRL_HALT = 3;

  typedef enum logic [3:0] {
    G_NONE, G_CTRL, G_PEND, G_DB, G_DBSET, G_PMASK,
    G_SPEND, G_SMASK, G_CPEND, G_CMASK
  } gsel_e;
endpackage

// File: rtl/dmag_decode.sv
module dmag_decode
  import dmag_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 13,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              is_ch_o,
  output logic [CH_W-1:0]   ch_idx_o,
  output logic [2:0]        ch_word_o,
  output gsel_e             gsel_o
);
  localparam int CHF_W = ADDR_W - 1 - WIN_LSB;
  localparam logic [CHF_W-1:0] CH_LIM = CHF_W'(NUM_CH);

  logic aligned, glb_hit;

  assign aligned   = (addr_i[1:0] == 2'b00);
  assign is_ch_o   = aligned && !addr_i[ADDR_W-1] && (addr_i[ADDR_W-2:WIN_LSB] < CH_LIM);
  assign ch_idx_o  = addr_i[WIN_LSB+CH_W-1:WIN_LSB];
  assign ch_word_o = addr_i[4:2];
  assign glb_hit   = aligned && addr_i[ADDR_W-1] && (addr_i[ADDR_W-2:6] == '0);

  always_comb begin
    gsel_o = G_NONE;
    if (glb_hit) begin
      unique case (addr_i[5:2])
        4'h0:    gsel_o = G_CTRL;
        4'h1:    gsel_o = G_PEND;
        4'h2:    gsel_o = G_DB;
        4'h3:    gsel_o = G_DBSET;
        4'h7:    gsel_o = G_PMASK;
        4'h8:    gsel_o = G_SPEND;
        4'h9:    gsel_o = G_SMASK;
        4'ha:    gsel_o = G_CPEND;
        4'hb:    gsel_o = G_CMASK;
        default: gsel_o = G_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dmag_doorbell.sv
module dmag_doorbell #(
  parameter int NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] ack_i,
  output logic [NUM_CH-1:0] db_o
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
    logic db_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       db_q <= 1'b0;
      else if (set_i[n]) db_q <= 1'b1;   // new request beats a stale ack
      else if (ack_i[n]) db_q <= 1'b0;
    end
    assign db_o[n] = db_q;

    a_r5_db_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[n] |=> db_q);
    a_r6_db_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (db_q && !ack_i[n]) |=> db_q);
  end
endmodule

// File: rtl/dmag_events.sv
module dmag_events
  import dmag_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] done_i,
  input  logic [NUM_CH-1:0] halt_i,
  input  logic [NUM_CH-1:0] aerr_i,
  input  logic              pend_wr_i,
  input  logic [NUM_CH-1:0] pend_keep_i,
  input  logic              ctrl_wr_i,
  input  logic              halt_keep_i,
  input  logic              aerr_keep_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic              halt_o,
  output logic              aerr_o
);
  logic [NUM_CH-1:0] ev;
  logic halt_q, aerr_q;

  assign ev = done_i | halt_i | aerr_i;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_pend
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        pend_q <= 1'b0;
      else if (ev[n])     pend_q <= 1'b1;
      else if (pend_wr_i) pend_q <= pend_q & pend_keep_i[n];
    end
    assign pend_o[n] = pend_q;

    a_r4_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev[n] |=> pend_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q <= 1'b0;
      aerr_q <= 1'b0;
    end else begin
      if (|halt_i)                      halt_q <= 1'b1;
      else if (ctrl_wr_i && !halt_keep_i) halt_q <= 1'b0;
      if (|aerr_i)                      aerr_q <= 1'b1;
      else if (ctrl_wr_i && !aerr_keep_i) aerr_q <= 1'b0;
    end
  end

  assign halt_o = halt_q;
  assign aerr_o = aerr_q;

  a_r3_halt_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|halt_i) |=> halt_q);
  a_r3_aerr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|aerr_i) |=> aerr_q);
  a_r3_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_q && !(ctrl_wr_i && !halt_keep_i)) |=> halt_q);
endmodule

// File: rtl/dma_glb_regs.sv
module dma_glb_regs
  import dmag_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  output logic [NUM_CH-1:0]              ch_wr_o,
  output logic [NUM_CH-1:0]              ch_rd_o,
  output logic [2:0]                     ch_word_o,
  output logic [DATA_W-1:0]              ch_wdata_o,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_rdata_i,
  input  logic [NUM_CH-1:0]              done_i,
  input  logic [NUM_CH-1:0]              halt_i,
  input  logic [NUM_CH-1:0]              aerr_i,
  input  logic [NUM_CH-1:0]              fetch_ack_i,
  output logic [NUM_CH-1:0]              db_o,
  output logic [DATA_W-1:0]              prog_mask_o,
  output logic                           irq_o
);
  localparam int CH_W      = $clog2(NUM_CH);
  localparam int CTRL_PERF = DATA_W - 1;

  logic              is_ch;
  logic [CH_W-1:0]   ch_idx;
  gsel_e             gsel;
  logic              wr, rd;
  logic [NUM_CH-1:0] pend, db_set;
  logic              halt_f, aerr_f;
  logic              en_q, perf_q;
  logic [DATA_W-1:0] pmask_q, spend_q, smask_q, cpend_q, cmask_q;

  dmag_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .is_ch_o   (is_ch),
    .ch_idx_o  (ch_idx),
    .ch_word_o (ch_word_o),
    .gsel_o    (gsel)
  );

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  // Channel window routing
  assign ch_wr_o    = (wr && is_ch) ? (NUM_CH'(1) << ch_idx) : '0;
  assign ch_rd_o    = (rd && is_ch) ? (NUM_CH'(1) << ch_idx) : '0;
  assign ch_wdata_o = wdata_i;

  assign db_set = (wr && gsel == G_DBSET) ? wdata_i[NUM_CH-1:0] : '0;

  dmag_doorbell #(.NUM_CH(NUM_CH)) u_db (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (db_set),
    .ack_i  (fetch_ack_i),
    .db_o   (db_o)
  );

  dmag_events #(.NUM_CH(NUM_CH)) u_ev (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done_i),
    .halt_i      (halt_i),
    .aerr_i      (aerr_i),
    .pend_wr_i   (wr && gsel == G_PEND),
    .pend_keep_i (wdata_i[NUM_CH-1:0]),
    .ctrl_wr_i   (wr && gsel == G_CTRL),
    .halt_keep_i (wdata_i[CTRL_HALT]),
    .aerr_keep_i (wdata_i[CTRL_AERR]),
    .pend_o      (pend),
    .halt_o      (halt_f),
    .aerr_o      (aerr_f)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      perf_q  <= 1'b0;
      pmask_q <= '0;
      spend_q <= '0;
      smask_q <= '0;
      cpend_q <= '0;
      cmask_q <= '0;
    end else if (wr) begin
      unique case (gsel)
        G_CTRL: begin
          en_q   <= wdata_i[CTRL_EN];
          perf_q <= wdata_i[CTRL_PERF];
        end
        G_PMASK: pmask_q <= wdata_i;
        G_SPEND: spend_q <= wdata_i;
        G_SMASK: smask_q <= wdata_i;
        G_CPEND: cpend_q <= wdata_i;
        G_CMASK: cmask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (is_ch) begin
      rdata_o = ch_rdata_i[ch_idx];
    end else begin
      unique case (gsel)
        G_CTRL: begin
          rdata_o[CTRL_EN]   = en_q;
          rdata_o[CTRL_AERR] = aerr_f;
          rdata_o[CTRL_HALT] = halt_f;
          rdata_o[CTRL_PERF] = perf_q;
        end
        G_PEND:        rdata_o = DATA_W'(pend);
        G_DB, G_DBSET: rdata_o = DATA_W'(db_o);
        G_PMASK:       rdata_o = pmask_q;
        G_SPEND:       rdata_o = spend_q;
        G_SMASK:       rdata_o = smask_q;
        G_CPEND:       rdata_o = cpend_q;
        G_CMASK:       rdata_o = cmask_q;
        default:       rdata_o = '0;
      endcase
    end
  end

  assign prog_mask_o = pmask_q;
  assign irq_o       = en_q && (|pend);

  a_r10_unmapped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !is_ch && gsel == G_NONE && !(|(done_i | halt_i | aerr_i)))
      |=> ($stable(pend) && $stable(en_q) && $stable(perf_q) && $stable(pmask_q)
           && !halt_f == !$past(halt_f)));
  a_r1_route_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr_o | ch_rd_o));
endmodule

// File: tb/sim_dma_glb_regs.sv
module sim_dma_glb_regs;
  localparam int CLK_T = 10;
  localparam int NCH   = 32;

  logic clk = 1'b0;
  always #(CLK_T/2) clk = ~clk;

  logic             rst_n;
  logic             req, we;
  logic [12:0]      addr;
  logic [31:0]      wdata, rdata;
  logic [31:0]      ch_wr, ch_rd;
  logic [2:0]       ch_word;
  logic [31:0]      ch_wdata;
  logic [NCH-1:0][31:0] ch_rdata;
  logic [31:0]      done, halt, aerr, ack, db, pmask;
  logic             irq;

  dma_glb_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ch_wr_o(ch_wr), .ch_rd_o(ch_rd),
    .ch_word_o(ch_word), .ch_wdata_o(ch_wdata), .ch_rdata_i(ch_rdata),
    .done_i(done), .halt_i(halt), .aerr_i(aerr), .fetch_ack_i(ack),
    .db_o(db), .prog_mask_o(pmask), .irq_o(irq)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] s_wr, s_rd, s_wdata;
  logic [2:0]  s_word;
  logic [31:0] e_ctrl, e_pend, e_db, rv;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1;
    s_wr = ch_wr; s_word = ch_word; s_wdata = ch_wdata;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata; s_rd = ch_rd;
    req = 1'b0;
  endtask

  task automatic rd_chk(input string rq, input logic [12:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(rq, v, exp);
  endtask

  task automatic pulse(input logic [31:0] d, input logic [31:0] h, input logic [31:0] e,
                       input logic [31:0] k);
    @(negedge clk);
    done = d; halt = h; aerr = e; ack = k;
    @(negedge clk);
    done = '0; halt = '0; aerr = '0; ack = '0;
  endtask

  function automatic logic [31:0] chpat(input int n);
    return {8'hCA, 8'(n), 8'h5A, 8'(~n)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual running expected finished");
    n_bad++;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] st_off [5];
    logic [31:0] st_val [5];
    logic [12:0] um [12];

    for (int n = 0; n < NCH; n++) ch_rdata[n] = chpat(n);
    rst_n = 1'b0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    done = '0; halt = '0; aerr = '0; ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd_chk("R11 ctrl", 13'h1000, 32'h0);
    rd_chk("R11 pend", 13'h1004, 32'h0);
    rd_chk("R11 db", 13'h1008, 32'h0);
    rd_chk("R11 pmask", 13'h101C, 32'h0);
    chk("R11 irq", {31'b0, irq}, 32'h0);
    chk("R11 db_o", db, 32'h0);

    // R1 channel window sweep
    for (int n = 0; n < NCH; n++) begin
      for (int w = 0; w < 8; w += 3) begin
        wr(13'(n*32 + w*4), 32'h1000_0000 + 32'(n*8 + w));
        chk("R1 wr strobe", s_wr, 32'h1 << n);
        chk("R1 word", {29'b0, s_word}, 32'(w));
        chk("R1 wdata", s_wdata, 32'h1000_0000 + 32'(n*8 + w));
      end
      rd(13'(n*32 + 4), rv);
      chk("R1 rdata", rv, chpat(n));
      chk("R1 rd strobe", s_rd, 32'h1 << n);
    end

    // R2 control word
    wr(13'h1000, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl ones", 13'h1000, 32'h8000_0001);
    wr(13'h1000, 32'h0);
    rd_chk("R2 ctrl zero", 13'h1000, 32'h0);
    wr(13'h1000, 32'h8000_0001);
    e_ctrl = 32'h8000_0001;
    rd_chk("R2 ctrl set", 13'h1000, e_ctrl);

    // R4/R3 event sweep: kind rotates done, halt, aerr
    e_pend = '0;
    for (int n = 0; n < NCH; n++) begin
      case (n % 3)
        0: pulse(32'h1 << n, '0, '0, '0);
        1: begin pulse('0, 32'h1 << n, '0, '0); e_ctrl |= 32'h8; end
        default: begin pulse('0, '0, 32'h1 << n, '0); e_ctrl |= 32'h4; end
      endcase
      e_pend |= 32'h1 << n;
      rd_chk("R4 pend accumulate", 13'h1004, e_pend);
      rd_chk("R3 flags", 13'h1000, e_ctrl);
      chk("R9 irq on", {31'b0, irq}, 32'h1);
    end
    wr(13'h1004, 32'hFFFF_0000);
    e_pend &= 32'hFFFF_0000;
    rd_chk("R4 partial clear", 13'h1004, e_pend);
    wr(13'h1000, 32'h8000_0005);
    rd_chk("R3 clear halt keep aerr", 13'h1000, 32'h8000_0005);
    wr(13'h1000, 32'h8000_0001);
    rd_chk("R3 clear aerr", 13'h1000, 32'h8000_0001);

    // R4 event beats clearing write
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 13'h1004; wdata = 32'h0; done = 32'h80;
    @(negedge clk);
    req = 1'b0; we = 1'b0; done = '0;
    rd_chk("R4 event wins", 13'h1004, 32'h80);

    // R3 event beats clearing write
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 13'h1000; wdata = 32'h8000_0001; halt = 32'h8;
    @(negedge clk);
    req = 1'b0; we = 1'b0; halt = '0;
    rd_chk("R3 event wins", 13'h1000, 32'h8000_0009);
    wr(13'h1000, 32'h8000_0001);
    rd_chk("R3 cleared", 13'h1000, 32'h8000_0001);

    // R9 interrupt gating
    wr(13'h1000, 32'h0);
    rd_chk("R9 ctrl off", 13'h1000, 32'h0);
    chk("R9 irq gated", {31'b0, irq}, 32'h0);
    wr(13'h1000, 32'h1);
    rd_chk("R9 ctrl on", 13'h1000, 32'h1);
    chk("R9 irq enabled", {31'b0, irq}, 32'h1);
    wr(13'h1004, 32'h0);
    rd_chk("R9 pend cleared", 13'h1004, 32'h0);
    chk("R9 irq idle", {31'b0, irq}, 32'h0);

    // R5 doorbell set
    wr(13'h100C, 32'h0000_00A5);
    rd_chk("R5 db status", 13'h1008, 32'h0000_00A5);
    wr(13'h100C, 32'h0F00_0000);
    e_db = 32'h0F00_00A5;
    rd_chk("R5 db zeros keep", 13'h100C, e_db);
    wr(13'h1008, 32'hFFFF_FFFF);
    rd_chk("R5 status write ignored", 13'h1008, e_db);
    chk("R5 db_o", db, e_db);

    // R6 acknowledge
    pulse('0, '0, '0, 32'h1);
    e_db &= ~32'h1;
    rd_chk("R6 ack clears", 13'h1008, e_db);
    pulse('0, '0, '0, 32'hFFFF_FFFF);
    rd_chk("R6 ack all", 13'h1008, 32'h0);
    for (int n = 0; n < NCH; n++) begin
      wr(13'h100C, 32'h1 << n);
      rd_chk("R5 single set", 13'h1008, 32'h1 << n);
      chk("R6 hold until ack", db, 32'h1 << n);
      pulse('0, '0, '0, 32'h1 << n);
      rd_chk("R6 single ack", 13'h1008, 32'h0);
    end
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 13'h100C; wdata = 32'h10; ack = 32'h10;
    @(negedge clk);
    req = 1'b0; we = 1'b0; ack = '0;
    rd_chk("R6 set beats ack", 13'h1008, 32'h10);

    // R7/R8 storage words
    st_off = '{13'h101C, 13'h1020, 13'h1024, 13'h1028, 13'h102C};
    for (int k = 0; k < 5; k++) begin
      st_val[k] = 32'h1357_9BDF ^ (32'(k) * 32'h0101_0101) ^ {19'b0, st_off[k]};
      wr(st_off[k], st_val[k]);
    end
    for (int k = 0; k < 5; k++)
      rd_chk(k == 0 ? "R7 pmask" : "R8 storage", st_off[k], st_val[k]);
    chk("R7 prog_mask_o", pmask, st_val[0]);

    // R10 unmapped
    um = '{13'h1010, 13'h1014, 13'h1018, 13'h1030, 13'h1034, 13'h1038,
           13'h103C, 13'h0400, 13'h0800, 13'h0FFC, 13'h1040, 13'h1001};
    for (int k = 0; k < 12; k++) begin
      wr(um[k], 32'hFFFF_FFFF);
      chk("R10 no strobe", s_wr, 32'h0);
      rd_chk("R10 reads zero", um[k], 32'h0);
    end
    wr(13'h1FFC, 32'hFFFF_FFFF);
    rd_chk("R10 top reads zero", 13'h1FFC, 32'h0);
    rd(13'h0022, rv);
    chk("R10 misaligned channel", rv, 32'h0);
    chk("R10 misaligned no strobe", s_rd, 32'h0);
    rd_chk("R10 ctrl intact", 13'h1000, 32'h1);
    rd_chk("R10 pend intact", 13'h1004, 32'h0);
    rd_chk("R10 db intact", 13'h1008, 32'h10);
    for (int k = 0; k < 5; k++)
      rd_chk("R10 storage intact", st_off[k], st_val[k]);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule